// File: doc/BRIEF.md
# AGC Gain-Word Loop with Pulse-Density Output

This block closes the automatic gain control loop of a sampled I/Q receiver. Every valid sample pair adds the magnitudes of its I and Q values into a running amplitude estimate. After a fixed block of valid samples (2048 by default) that estimate is compared with a programmable target. The gain word then steps up when the signal is too weak and down when it is too strong, by a programmable step, and it saturates at both ends of its range.

The gain word feeds a first-order pulse-density modulator that advances once every four clocks. Its carry becomes a single output bit. After an external RC low-pass filter, that bit sets the analog amplifier gain. A mode input selects how the pad is driven. In push-pull mode both levels are driven. In open-drain mode only the low level is driven, and the pin is released for high.

Top module: `agc_pdm_ctrl`

## Requirements
- R1: After reset the gain word is mid-scale (2^(GAIN_W-1)), the output bit is 0 (push-pull pad low with enable high), and gain_upd_o is low.
- R2: The amplitude of a block is the sum of |I|+|Q| over 2^BLK_LOG2 valid samples, with the samples read as two's complement. Cycles with smp_valid_i low add nothing. The block closes on its last valid sample, and the next valid sample opens a new block from zero.
- R3: When the clock edge that captures a block's last sample is edge k, target_i and step_i are sampled in the cycle after edge k. The new gain word appears at edge k+1, and gain_upd_o is high for exactly that one cycle. There is one pulse per block.
- R4: A block sum below target raises the gain word by step_i, clipped at 2^GAIN_W-1.
- R5: A block sum above target lowers the gain word by step_i, clipped at 0.
- R6: A block sum equal to target leaves the gain word unchanged. gain_upd_o still pulses.
- R7: While the gain word holds a value g, any 2^GAIN_W consecutive modulator steps produce exactly g ones.
- R8: The modulator steps once every 2^DIV_LOG2 clocks (every 4 by default). The output bit changes only on a step, so every level lasts a multiple of 4 clocks.
- R9: With od_mode_i low, pad_oe_o is 1 and pad_o carries the output bit.
- R10: With od_mode_i high, pad_o is 0 and pad_oe_o is 1 exactly when the output bit is 0. The line then floats high whenever the bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | AGC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_i_i | input | SMP_W | I sample, two's complement |
| smp_q_i | input | SMP_W | Q sample, two's complement |
| target_i | input | SMP_W+BLK_LOG2+1 | Target block amplitude |
| step_i | input | GAIN_W | Gain adjustment step |
| od_mode_i | input | 1 | 1: open-drain drive, 0: push-pull |
| gain_o | output | GAIN_W | Current gain word |
| gain_upd_o | output | 1 | One-cycle pulse when a block updates the gain |
| pad_o | output | 1 | Pad data |
| pad_oe_o | output | 1 | Pad output enable |

## Verification
Two events fall in the same cycle in this block. The first is the close of a block, where the last sample is folded into the sum while the accumulator restarts. The second is the next block's first sample, which arrives at the very next edge with no gap. The bench provokes this by feeding all 4096 constant I/Q pairs of a 6-bit configuration as blocks back to back. Some blocks carry idle cycles, and each block uses its own target and step. A monitor compares every gain_upd_o pulse against an arithmetic model of the gain. Any leak of the closing sample into the next block, or any lost first sample, would shift a later gain value. Density is measured separately in both drive modes, at mid-scale and at both saturation limits.

// File: rtl/agc_pdm_pkg.sv
package agc_pdm_pkg;
  typedef enum logic [1:0] {
    GDIR_HOLD = 2'd0,
    GDIR_UP   = 2'd1,
    GDIR_DOWN = 2'd2
  } gain_dir_e;
endpackage

// File: rtl/agc_amp_est.sv
module agc_amp_est #(
  parameter int SMP_W    = 6,
  parameter int BLK_LOG2 = 11,
  localparam int SUM_W   = SMP_W + BLK_LOG2 + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [SMP_W-1:0]        smp_i_i,
  input  logic [SMP_W-1:0]        smp_q_i,
  output logic                    done_o,
  output logic [SUM_W-1:0]        sum_o
);
  logic [SMP_W-1:0]    mag_i, mag_q;
  logic [SMP_W:0]      mag;
  logic [BLK_LOG2-1:0] cnt_q;
  logic [SUM_W-1:0]    acc_q, acc_n;
  logic                last;

  // magnitude of most negative value still fits SMP_W bits unsigned
  assign mag_i = smp_i_i[SMP_W-1] ? (~smp_i_i + 1'b1) : smp_i_i;
  assign mag_q = smp_q_i[SMP_W-1] ? (~smp_q_i + 1'b1) : smp_q_i;
  assign mag   = {1'b0, mag_i} + {1'b0, mag_q};
  assign acc_n = acc_q + SUM_W'(mag);
  assign last  = valid_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      sum_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last;
      if (valid_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          acc_q <= '0;
          sum_o <= acc_n;
        end else begin
          acc_q <= acc_n;
        end
      end
    end
  end

  // R3: close pulse lasts one cycle (block holds at least two samples)
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop
  import agc_pdm_pkg::*;
#(
  parameter int GAIN_W = 8,
  parameter int SUM_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [SUM_W-1:0]  sum_i,
  input  logic [SUM_W-1:0]  target_i,
  input  logic [GAIN_W-1:0] step_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              upd_o
);
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;
  localparam logic [GAIN_W-1:0] GAIN_MID = GAIN_W'(1) << (GAIN_W - 1);

  gain_dir_e         dir;
  logic [GAIN_W:0]   up_sum;
  logic [GAIN_W-1:0] up_val, dn_val, gain_n;

  always_comb begin
    if (sum_i < target_i)      dir = GDIR_UP;
    else if (sum_i > target_i) dir = GDIR_DOWN;
    else                       dir = GDIR_HOLD;
  end

  assign up_sum = {1'b0, gain_o} + {1'b0, step_i};
  assign up_val = up_sum[GAIN_W] ? GAIN_MAX : up_sum[GAIN_W-1:0];
  assign dn_val = (step_i > gain_o) ? '0 : (gain_o - step_i);

  always_comb begin
    unique case (dir)
      GDIR_UP:   gain_n = up_val;
      GDIR_DOWN: gain_n = dn_val;
      default:   gain_n = gain_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o <= GAIN_MID;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= done_i;
      if (done_i) gain_o <= gain_n;
    end
  end

  a_r4_up_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (sum_i < target_i)) |=> (gain_o >= $past(gain_o)));
  a_r5_down_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (sum_i > target_i)) |=> (gain_o <= $past(gain_o)));
  a_r6_equal_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (sum_i == target_i)) |=> $stable(gain_o));
  a_r3_quiet_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(gain_o));
endmodule

// File: rtl/agc_pdm_mod.sv
module agc_pdm_mod #(
  parameter int GAIN_W   = 8,
  parameter int DIV_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              bit_o
);
  logic              tick;
  logic [GAIN_W-1:0] pacc_q;
  logic [GAIN_W:0]   pacc_n;

  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_LOG2-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_q + 1'b1;
      end
      assign tick = &div_q;
    end
  endgenerate

  assign pacc_n = {1'b0, pacc_q} + {1'b0, gain_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pacc_q <= '0;
      bit_o  <= 1'b0;
    end else if (tick) begin
      pacc_q <= pacc_n[GAIN_W-1:0];
      bit_o  <= pacc_n[GAIN_W];
    end
  end

  a_r8_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_o) |-> $past(tick));
endmodule

// File: rtl/agc_pdm_ctrl.sv
module agc_pdm_ctrl #(
  parameter int SMP_W    = 6,
  parameter int BLK_LOG2 = 11,
  parameter int GAIN_W   = 8,
  parameter int DIV_LOG2 = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      smp_valid_i,
  input  logic [SMP_W-1:0]          smp_i_i,
  input  logic [SMP_W-1:0]          smp_q_i,
  input  logic [SMP_W+BLK_LOG2:0]   target_i,
  input  logic [GAIN_W-1:0]         step_i,
  input  logic                      od_mode_i,
  output logic [GAIN_W-1:0]         gain_o,
  output logic                      gain_upd_o,
  output logic                      pad_o,
  output logic                      pad_oe_o
);
  localparam int SUM_W = SMP_W + BLK_LOG2 + 1;

  logic             blk_done;
  logic [SUM_W-1:0] blk_sum;
  logic             pdm_bit;

  agc_amp_est #(.SMP_W(SMP_W), .BLK_LOG2(BLK_LOG2)) u_est (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .smp_i_i (smp_i_i),
    .smp_q_i (smp_q_i),
    .done_o  (blk_done),
    .sum_o   (blk_sum)
  );

  agc_gain_loop #(.GAIN_W(GAIN_W), .SUM_W(SUM_W)) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (blk_done),
    .sum_i    (blk_sum),
    .target_i (target_i),
    .step_i   (step_i),
    .gain_o   (gain_o),
    .upd_o    (gain_upd_o)
  );

  agc_pdm_mod #(.GAIN_W(GAIN_W), .DIV_LOG2(DIV_LOG2)) u_mod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gain_i (gain_o),
    .bit_o  (pdm_bit)
  );

  // open-drain: drive only the low level
  assign pad_o    = od_mode_i ? 1'b0 : pdm_bit;
  assign pad_oe_o = od_mode_i ? ~pdm_bit : 1'b1;

  a_r3_upd_follows_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done |=> gain_upd_o);
endmodule

// File: tb/agc_pdm_ctrl_tb.sv
module agc_pdm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SMP_W    = 6;
  localparam int BLK_LOG2 = 3;
  localparam int GAIN_W   = 6;
  localparam int DIV_LOG2 = 2;
  localparam int BLK      = 1 << BLK_LOG2;
  localparam int GMAX     = (1 << GAIN_W) - 1;
  localparam int NEXP     = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [SMP_W-1:0] si = '0, sq = '0;
  logic [SMP_W+BLK_LOG2:0] tgt = '0;
  logic [GAIN_W-1:0] stp = '0;
  logic od = 1'b0;
  logic [GAIN_W-1:0] gain;
  logic upd, pad, oe;

  int checks = 0, fails = 0;
  int exp_gain[NEXP];
  int n_blk = 0, n_upd = 0;
  int g_model = 1 << (GAIN_W - 1);
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_pdm_ctrl #(.SMP_W(SMP_W), .BLK_LOG2(BLK_LOG2), .GAIN_W(GAIN_W),
                 .DIV_LOG2(DIV_LOG2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_i_i(si),
    .smp_q_i(sq), .target_i(tgt), .step_i(stp), .od_mode_i(od),
    .gain_o(gain), .gain_upd_o(upd), .pad_o(pad), .pad_oe_o(oe));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int next_gain(input int g, input int s, input int t, input int st);
    if (s < t)      return (g + st > GMAX) ? GMAX : g + st;
    else if (s > t) return (st > g) ? 0 : g - st;
    return g;
  endfunction

  // R3/R4/R5/R6: every update pulse compared with the model
  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (n_upd < n_blk)
        check(int'(gain) == exp_gain[n_upd], "R4/R5/R6 gain", int'(gain), exp_gain[n_upd]);
      else
        check(1'b0, "R3 extra pulse", n_upd, n_blk);
      n_upd++;
    end
  end

  // R2: one block of constant I/Q; target/step applied from 2nd sample
  task automatic run_block(input int i, input int q, input int t, input int st, input bit gap);
    for (int k = 0; k < BLK; k++) begin
      if (gap && k == 3) begin
        @(negedge clk); valid = 1'b0;
        @(negedge clk); valid = 1'b0;
      end
      @(negedge clk);
      valid = 1'b1; si = SMP_W'(i); sq = SMP_W'(q);
      if (k == 1) begin
        tgt = (SMP_W+BLK_LOG2+1)'(t);
        stp = GAIN_W'(st);
      end
    end
    g_model = next_gain(g_model, BLK * (iabs(i) + iabs(q)), t, st);
    exp_gain[n_blk] = g_model;
    n_blk++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); valid = 1'b0;
    end
  endtask

  // R7/R8/R9/R10: density and run length over 2^GAIN_W modulator steps
  task automatic measure(input bit odm, input int expg);
    int ones = 0, run = 0;
    bit first = 1, prev = 0, lvl;
    @(negedge clk); od = odm;
    idle(12);
    for (int c = 0; c < 4 * (GMAX + 1); c++) begin
      @(negedge clk);
      lvl = oe ? pad : 1'b1;
      if (odm) check(pad == 1'b0, "R10 pad low", int'(pad), 0);
      else     check(oe == 1'b1, "R9 enable", int'(oe), 1);
      if (c % 4 == 0) ones += int'(lvl);
      if (c > 0 && lvl != prev) begin
        if (!first) check(run % 4 == 0, "R8 run length", run, 4);
        first = 0;
        run = 1;
      end else begin
        run++;
      end
      prev = lvl;
    end
    check(ones == expg, odm ? "R7/R10 density" : "R7/R9 density", ones, expg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(gain) == (1 << (GAIN_W-1)), "R1 gain", int'(gain), 1 << (GAIN_W-1));
    check(pad == 1'b0 && oe == 1'b1, "R1 pad", {pad, oe}, 1);
    check(upd == 1'b0, "R1 upd", int'(upd), 0);

    measure(1'b0, g_model);
    measure(1'b1, g_model);
    od = 1'b0;

    // R2/R3 exhaustive constant I/Q sweep, back to back
    for (int i = -32; i < 32; i++)
      for (int q = -32; q < 32; q++)
        run_block(i, q, ((i + 32) * 37 + (q + 32) * 11) % 520,
                  ((i + q + 64) % 13) + 1, ((i ^ q) & 1) == 1);
    // R6 equal case
    run_block(3, -2, BLK * 5, 7, 1'b0);
    // R4 saturate high
    for (int k = 0; k < 8; k++) run_block(0, 0, 1000, 13, 1'b0);
    idle(4);
    check(int'(gain) == GMAX, "R4 saturate", int'(gain), GMAX);
    measure(1'b0, GMAX);
    measure(1'b1, GMAX);
    // R5 floor at zero
    for (int k = 0; k < 8; k++) run_block(-32, 31, 0, 11, 1'b0);
    idle(4);
    check(int'(gain) == 0, "R5 floor", int'(gain), 0);
    measure(1'b0, 0);
    measure(1'b1, 0);
    // R7 at an intermediate value
    run_block(5, 5, 1000, 23, 1'b0);
    idle(4);
    measure(1'b0, g_model);
    measure(1'b1, g_model);
    check(n_upd == n_blk, "R3 pulse count", n_upd, n_blk);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule